// File: doc/BRIEF.md
# Serial-Loaded Eight-Channel Output Latch

This block takes a serial bit stream from a host and turns it into a parallel word that switches a bank of output channels. While the active-low select is held low, each rising edge of the serial clock shifts one bit into a shift register, most significant bit first. When select is released, the shift register is copied into the output register. The copy happens only when the number of clock edges seen during that select window is a nonzero whole multiple of the channel count. Any other frame is thrown away and the outputs keep their previous value.

The block runs on the serial clock itself. Select and disable act asynchronously. A serial data output, with a separate enable for the pad, carries the oldest bit of the shift register so that several devices can be chained on one clock and select. An active-low disable input clears the output register and the shift register at once. The outputs then stay off after disable is released, until a new valid frame is committed. A frame-accepted flag tells a downstream block whether the last transfer was taken.

Top module: `spi_out_latch`

## Requirements
- R1: On each rising edge of `sclk_i` while `sel_n_i` is low, `si_i` is shifted in at bit 0 of the shift register and the older bits move up one place. After an accepted frame, `chan_o` holds the last 8 bits received, with the earliest of them in `chan_o[7]`. A 1 in `chan_o` means the channel is on.
- R2: On the rising edge of `sel_n_i`, the shift register is copied to `chan_o` only if the number of `sclk_i` rising edges during the select window was 8, 16, 24 and so on. After a window with 0, 5, 7, 9 or 12 edges, `chan_o` keeps its previous value.
- R3: `frame_ok_o` is high from the release of select after an accepted frame until the next fall of `sel_n_i`. It is low after a rejected frame.
- R4: `so_oe_o` is 1 while `sel_n_i` is low and 0 while it is high.
- R5: `so_o` changes only after a falling edge of `sclk_i`, and then shows bit 7 of the shift register. From the fall of `sel_n_i` until the first falling edge of `sclk_i`, `so_o` shows the current bit 7 of the shift register.
- R6: In a frame longer than 8 clocks, `so_o` after falling edge k (k = 8 or more, counted from 0) equals the bit that entered on rising edge k-8. The bits received 8 clocks earlier therefore come out in order, for daisy-chaining.
- R7: While `sel_n_i` is high, `sclk_i` and `si_i` change neither the shift register nor `chan_o`.
- R8: While `dis_n_i` is low, `chan_o` and `frame_ok_o` are 0 without waiting for any clock edge, and the shift register is cleared.
- R9: After `dis_n_i` returns high, `chan_o` stays 0 through rejected frames until a valid frame is committed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sclk_i | input | 1 | Serial clock; data is sampled on its rising edge |
| sel_n_i | input | 1 | Active-low frame select; its rising edge ends the frame |
| si_i | input | 1 | Serial data in, most significant bit first |
| dis_n_i | input | 1 | Active-low asynchronous disable and clear |
| so_o | output | 1 | Serial data out for daisy-chaining |
| so_oe_o | output | 1 | Pad enable for `so_o`; the pad is high impedance when this is 0 |
| chan_o | output | W (8) | Channel on/off word |
| frame_ok_o | output | 1 | High after an accepted frame, until the next select |

## Verification
The clocked checks assume that select and disable never change at a serial clock edge. They also assume that select and disable each stay at one level across at least one rising clock edge, so no commit or clear can hide between two sampled edges. The bench runs a free-running clock, changes select only in the middle of the clock-high phase, and holds select high for two full periods between frames. The one exception is the zero-clock frame: there select is pulsed low within a single high phase and no edge occurs, which is exactly the case that frame is meant to exercise.

// File: rtl/slc_pkg.sv
package slc_pkg;
  // Status of the clock-edge counter at the end of a select window
  typedef struct packed {
    logic seen;     // at least one rising edge counted
    logic aligned;  // edge count is a whole multiple of the frame size
  } frame_stat_t;
endpackage

// File: rtl/slc_shifter.sv
module slc_shifter #(
  parameter int W = 8
) (
  input  logic         sclk_i,
  input  logic         sel_n_i,
  input  logic         si_i,
  input  logic         dis_n_i,
  output logic [W-1:0] sh_o
);
  logic [W-1:0] sh_q;

  // Shift only while selected; disable clears the register asynchronously
  always_ff @(posedge sclk_i or negedge dis_n_i) begin
    if (!dis_n_i) begin
      sh_q <= '0;
    end else if (!sel_n_i) begin
      sh_q <= {sh_q[W-2:0], si_i};
    end
  end

  assign sh_o = sh_q;
endmodule

// File: rtl/slc_edge_count.sv
module slc_edge_count
  import slc_pkg::*;
#(
  parameter int W = 8
) (
  input  logic        sclk_i,
  input  logic        sel_n_i,
  output frame_stat_t stat_o
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [CW-1:0] cnt_q;
  logic          seen_q;

  // Held at zero while select is high, so every window starts from zero
  always_ff @(posedge sclk_i or posedge sel_n_i) begin
    if (sel_n_i) begin
      cnt_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      seen_q <= 1'b1;
      cnt_q  <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  always_comb begin
    stat_o.seen    = seen_q;
    stat_o.aligned = (cnt_q == '0);
  end
endmodule

// File: rtl/slc_commit.sv
module slc_commit
  import slc_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         sel_n_i,
  input  logic         dis_n_i,
  input  frame_stat_t  stat_i,
  input  logic [W-1:0] sh_i,
  output logic [W-1:0] chan_o,
  output logic         frame_ok_o
);
  logic [W-1:0] chan_q;
  logic         ok_q;
  logic         take;

  assign take = stat_i.seen & stat_i.aligned;

  // The release of select is the commit event; disable overrides it
  always_ff @(posedge sel_n_i or negedge dis_n_i) begin
    if (!dis_n_i) begin
      chan_q <= '0;
      ok_q   <= 1'b0;
    end else begin
      ok_q <= take;
      if (take) begin
        chan_q <= sh_i;
      end
    end
  end

  assign chan_o     = chan_q;
  assign frame_ok_o = ok_q & sel_n_i;
endmodule

// File: rtl/slc_so_drv.sv
module slc_so_drv (
  input  logic sclk_i,
  input  logic sel_n_i,
  input  logic dis_n_i,
  input  logic msb_i,
  output logic so_o,
  output logic so_oe_o
);
  logic so_q;
  logic fell_q;

  // Retimes the shift-register top bit to the falling edge
  always_ff @(negedge sclk_i or negedge dis_n_i) begin
    if (!dis_n_i) begin
      so_q <= 1'b0;
    end else if (!sel_n_i) begin
      so_q <= msb_i;
    end
  end

  // Marks that a falling edge has occurred in the current window
  always_ff @(negedge sclk_i or posedge sel_n_i) begin
    if (sel_n_i) begin
      fell_q <= 1'b0;
    end else begin
      fell_q <= 1'b1;
    end
  end

  assign so_o    = fell_q ? so_q : msb_i;
  assign so_oe_o = ~sel_n_i;
endmodule

// File: rtl/spi_out_latch.sv
module spi_out_latch
  import slc_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         sclk_i,
  input  logic         sel_n_i,
  input  logic         si_i,
  input  logic         dis_n_i,
  output logic         so_o,
  output logic         so_oe_o,
  output logic [W-1:0] chan_o,
  output logic         frame_ok_o
);
  logic [W-1:0] sh;
  frame_stat_t  stat;

  slc_shifter #(.W(W)) u_shifter (
    .sclk_i (sclk_i),
    .sel_n_i(sel_n_i),
    .si_i   (si_i),
    .dis_n_i(dis_n_i),
    .sh_o   (sh)
  );

  slc_edge_count #(.W(W)) u_count (
    .sclk_i (sclk_i),
    .sel_n_i(sel_n_i),
    .stat_o (stat)
  );

  slc_commit #(.W(W)) u_commit (
    .sel_n_i   (sel_n_i),
    .dis_n_i   (dis_n_i),
    .stat_i    (stat),
    .sh_i      (sh),
    .chan_o    (chan_o),
    .frame_ok_o(frame_ok_o)
  );

  slc_so_drv u_so (
    .sclk_i (sclk_i),
    .sel_n_i(sel_n_i),
    .dis_n_i(dis_n_i),
    .msb_i  (sh[W-1]),
    .so_o   (so_o),
    .so_oe_o(so_oe_o)
  );
endmodule

// File: rtl/slc_checker.sv
module slc_checker #(
  parameter int W = 8
) (
  input logic         sclk_i,
  input logic         sel_n_i,
  input logic         dis_n_i,
  input logic         so_oe_o,
  input logic [W-1:0] chan_o
);
  // R4
  so_drive_chk: assert property (@(posedge sclk_i) disable iff (!dis_n_i)
    !sel_n_i |-> so_oe_o);

  // R4
  so_release_chk: assert property (@(negedge sclk_i) disable iff (!dis_n_i)
    sel_n_i |-> !so_oe_o);

  // R2
  chan_hold_chk: assert property (@(posedge sclk_i) disable iff (!dis_n_i)
    (!sel_n_i && $past(!sel_n_i)) |-> $stable(chan_o));

  // R7
  idle_ignore_chk: assert property (@(posedge sclk_i) disable iff (!dis_n_i)
    (sel_n_i && $past(sel_n_i)) |-> $stable(chan_o));

  // R8
  always_ff @(negedge sclk_i) begin
    if (!dis_n_i) begin
      dis_off_chk: assert (chan_o == '0);
    end
  end
endmodule

bind spi_out_latch slc_checker #(.W(W)) u_slc_checker (
  .sclk_i (sclk_i),
  .sel_n_i(sel_n_i),
  .dis_n_i(dis_n_i),
  .so_oe_o(so_oe_o),
  .chan_o (chan_o)
);

// File: tb/spi_out_latch_bench.sv
module spi_out_latch_bench;
  localparam int T  = 20;
  localparam int NV = 8;
  localparam int        V_LEN  [NV] = '{8, 16, 5, 8, 12, 9, 24, 7};
  localparam bit [31:0] V_DAT  [NV] = '{32'hA5, 32'h3CC3, 32'h1B, 32'h0F,
                                        32'hFFF, 32'h155, 32'h123456, 32'h7F};
  localparam bit [7:0]  V_CHAN [NV] = '{8'hA5, 8'hC3, 8'hC3, 8'h0F,
                                        8'h0F, 8'h0F, 8'h56, 8'h56};
  localparam bit        V_OK   [NV] = '{1'b1, 1'b1, 1'b0, 1'b1,
                                        1'b0, 1'b0, 1'b1, 1'b0};

  logic       sclk = 1'b1;
  logic       sel_n;
  logic       si;
  logic       dis_n;
  logic       so;
  logic       so_oe;
  logic [7:0] chan;
  logic       frame_ok;

  int         n_chk  = 0;
  int         n_fail = 0;
  bit         done   = 0;
  logic [7:0] m_sh;

  spi_out_latch #(.W(8)) u_spi_out_latch (
    .sclk_i    (sclk),
    .sel_n_i   (sel_n),
    .si_i      (si),
    .dis_n_i   (dis_n),
    .so_o      (so),
    .so_oe_o   (so_oe),
    .chan_o    (chan),
    .frame_ok_o(frame_ok)
  );

  // Rising edges at multiples of T, falling edges half a period later
  initial forever begin
    #(T/2) sclk = 1'b0;
    #(T/2) sclk = 1'b1;
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Entered and left at kT + T/4, with the clock high
  task automatic run_frame(int n, logic [31:0] dat, logic [7:0] e_chan, logic e_ok);
    sel_n = 1'b0;
    #1;
    chk("R5 R7 first SO bit at select", {31'b0, so}, {31'b0, m_sh[7]});
    chk("R4 SO enabled", {31'b0, so_oe}, 32'd1);
    for (int i = 0; i < n; i++) begin
      @(negedge sclk);
      #1 si = dat[n-1-i];
      #4;
      if (i >= 8) chk("R6 daisy bit", {31'b0, so}, {31'b0, dat[n-1-(i-8)]});
      else        chk("R5 SO after fall", {31'b0, so}, {31'b0, m_sh[7]});
      @(posedge sclk);
      m_sh = {m_sh[6:0], dat[n-1-i]};
    end
    #(T/4) sel_n = 1'b1;
    #1;
    chk("R1 R2 channel word", {24'b0, chan}, {24'b0, e_chan});
    chk("R3 frame accepted", {31'b0, frame_ok}, {31'b0, e_ok});
    chk("R4 SO released", {31'b0, so_oe}, 32'd0);
    #(T - 1);
    #(T);
  endtask

  initial begin
    #(T*5000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    dis_n = 1'b0;
    sel_n = 1'b1;
    si    = 1'b0;
    m_sh  = 8'h00;
    #(T/4);
    chk("R8 reset channels off", {24'b0, chan}, 32'd0);
    chk("R8 reset frame flag", {31'b0, frame_ok}, 32'd0);
    chk("R4 reset SO released", {31'b0, so_oe}, 32'd0);
    #(T) dis_n = 1'b1;
    #(T);

    for (int v = 0; v < NV; v++) begin
      run_frame(V_LEN[v], V_DAT[v], V_CHAN[v], V_OK[v]);
    end

    // R7: data and clock activity while deselected
    for (int k = 0; k < 3; k++) begin
      si = ~si;
      #(T);
    end
    chk("R7 channels untouched while idle", {24'b0, chan}, 32'h56);
    run_frame(8, 32'h3A, 8'h3A, 1'b1);

    // R2: select pulse with no clock edge inside it
    sel_n = 1'b0;
    #3 sel_n = 1'b1;
    #1;
    chk("R2 zero-edge frame keeps word", {24'b0, chan}, 32'h3A);
    chk("R3 zero-edge frame not accepted", {31'b0, frame_ok}, 32'd0);
    #(T - 4);

    run_frame(8, 32'h81, 8'h81, 1'b1);

    // R8: asynchronous disable with the clock high
    dis_n = 1'b0;
    #1;
    chk("R8 disable clears channels", {24'b0, chan}, 32'd0);
    chk("R8 disable clears frame flag", {31'b0, frame_ok}, 32'd0);
    #(T - 1);
    #(T);
    dis_n = 1'b1;
    m_sh  = 8'h00;
    #1;
    chk("R9 channels off after release", {24'b0, chan}, 32'd0);
    #(T - 1);
    run_frame(3, 32'h5, 8'h00, 1'b0);
    chk("R9 rejected frame keeps channels off", {24'b0, chan}, 32'd0);
    run_frame(8, 32'hC6, 8'hC6, 1'b1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule